// File: doc/BRIEF.md
# Three-Stage Pipeline Front End with Branch Control

This block is the instruction front end of a small three-stage core. It holds the program counter and presents it as the instruction-memory address. The memory is outside the block and returns the addressed word in the same cycle through an asynchronous read. Each word then moves through a decode register and an execute register, and leaves on a registered retire port together with its address. The register file, the arithmetic datapath and the memory system are not part of the block.

Branches are resolved only in the execute stage, where a single condition input says whether the branch is taken. Until then, fetch keeps running sequentially. Bit 11 of each branch word picks one of two behaviours. A squashing branch turns the two younger instructions into bubbles when it is taken. A delayed branch lets those two younger instructions retire whether or not it is taken. A stall input freezes the whole front end. A registered bubble flag marks every cycle in which nothing retires.

Top module: `branch_pipe_ctrl`

## Requirements
- R1: A synchronous active-high reset drives fetch_addr to 0. On the cycle after reset, retire_valid and bubble are low and the decode and execute slots are empty.
- R2: With no stall and no taken branch, fetch_addr rises by one every cycle. The word fetched while fetch_addr is A retires, with retire_pc equal to A, three clock edges later. Once the pipe is full, one instruction retires per cycle, so N instructions finish in 3 + (N-1) cycles.
- R3: A word is a branch exactly when bits [15:12] equal 4'hA. Bit 11 set marks a delayed branch. Bits [10:0] hold the absolute target address. Words with any other opcode are plain operations and retire in order.
- R4: A branch whose condition input is low while it is in execute causes no squash and no bubble. Fetch continues at the next sequential address.
- R5: A taken branch with bit 11 clear loads fetch_addr with its target on the next cycle. The two instructions that were behind it never retire, and bubble is high for the two cycles after the branch itself retires.
- R6: A taken branch with bit 11 set loads fetch_addr with its target on the next cycle. The two instructions that follow it still retire, back to back, with no bubble.
- R7: While stall is high, fetch_addr, exec_pc and every pipeline slot hold their values. In the next cycle retire_valid is low and bubble is high, and no instruction is lost or retired twice.
- R8: br_taken has no effect when execute holds a plain operation or an empty slot.
- R9: exec_pc shows the address of the valid instruction currently in execute.
- R10: bubble is high exactly in the cycles in which retire_valid is low, outside the cycle that follows reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze all stages and the program counter |
| br_taken | input | 1 | Condition of the branch now in execute |
| fetch_word | input | 16 | Instruction word read at fetch_addr |
| fetch_addr | output | 11 | Program counter, used as the instruction-memory address |
| exec_pc | output | 11 | Address of the instruction in execute |
| retire_valid | output | 1 | An instruction retired this cycle |
| retire_word | output | 16 | Retired instruction word |
| retire_pc | output | 11 | Address of the retired instruction |
| bubble | output | 1 | No instruction retired this cycle (stall or squashed slot) |

## Verification
The bench runs a looping program that contains squashing and delayed branches, both taken and not taken. One taken squashing branch sits at the first word of another branch's target, so two redirects happen close together. Random stalls land on cycles in which a branch sits in execute. Two faults are caught this way. A design that squashes one slot too few or too many would retire a wrong-path word or lose a target word. A design that resolves a branch during a stall would redirect twice or skip its delay slots. The condition input toggles randomly whenever execute holds a plain word or a bubble, which exposes a front end that redirects on a non-branch. A reset in the middle of the run checks that no stale slot retires afterwards.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int INSTR_W   = 16;
  localparam int OP_W      = 4;
  localparam int ADDR_W    = INSTR_W - OP_W - 1;
  localparam int OP_LSB    = INSTR_W - OP_W;
  localparam int DLY_BIT   = ADDR_W;
  localparam int STAGES    = 3;
  localparam int NUM_REG   = STAGES - 1;
  localparam logic [OP_W-1:0] OP_BRANCH = 4'hA;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] pc;
    logic [INSTR_W-1:0] word;
  } slot_t;
endpackage

// File: rtl/bpc_fetch.sv
module bpc_fetch
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)           pc <= '0;
    else if (!hold) begin
      if (redirect)    pc <= target;
      else             pc <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/bpc_slot_reg.sv
module bpc_slot_reg
  import bpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hold,
  input  logic  kill,
  input  slot_t d,
  output slot_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (!hold) begin
      q       <= d;
      q.valid <= d.valid && !kill;
    end
  end
endmodule

// File: rtl/bpc_resolve.sv
module bpc_resolve
  import bpc_pkg::*;
(
  input  slot_t             ex,
  input  logic              br_taken,
  input  logic              stall,
  output logic              redirect,
  output logic              squash,
  output logic [ADDR_W-1:0] target
);
  logic is_br;
  always_comb begin
    is_br    = ex.valid && (ex.word[INSTR_W-1:OP_LSB] == OP_BRANCH);
    redirect = is_br && br_taken && !stall;
    squash   = redirect && !ex.word[DLY_BIT];
    target   = ex.word[ADDR_W-1:0];
  end
endmodule

// File: rtl/branch_pipe_ctrl.sv
module branch_pipe_ctrl
  import bpc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               stall,
  input  logic               br_taken,
  input  logic [INSTR_W-1:0] fetch_word,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic [ADDR_W-1:0]  exec_pc,
  output logic               retire_valid,
  output logic [INSTR_W-1:0] retire_word,
  output logic [ADDR_W-1:0]  retire_pc,
  output logic               bubble
);
  logic              redirect, squash;
  logic [ADDR_W-1:0] target;
  slot_t             f_slot;
  slot_t             stage_q [NUM_REG];
  slot_t             ex;
  logic              ex_valid;
  logic [INSTR_W-1:0] ex_word;

  bpc_fetch u_fetch (
    .clk(clk), .rst(rst), .hold(stall),
    .redirect(redirect), .target(target), .pc(fetch_addr)
  );

  always_comb begin
    f_slot.valid = 1'b1;
    f_slot.pc    = fetch_addr;
    f_slot.word  = fetch_word;
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : g_stage
    slot_t stage_d;
    if (g == 0) begin : g_first
      assign stage_d = f_slot;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    bpc_slot_reg u_reg (
      .clk(clk), .rst(rst), .hold(stall), .kill(squash),
      .d(stage_d), .q(stage_q[g])
    );
  end

  assign ex       = stage_q[NUM_REG-1];
  assign ex_valid = ex.valid;
  assign ex_word  = ex.word;
  assign exec_pc  = ex.pc;

  bpc_resolve u_resolve (
    .ex(ex), .br_taken(br_taken), .stall(stall),
    .redirect(redirect), .squash(squash), .target(target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      retire_valid <= 1'b0;
      retire_word  <= '0;
      retire_pc    <= '0;
      bubble       <= 1'b0;
    end else begin
      retire_valid <= ex.valid && !stall;
      bubble       <= stall || !ex.valid;
      if (!stall) begin
        retire_word <= ex.word;
        retire_pc   <= ex.pc;
      end
    end
  end
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker
  import bpc_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               stall,
  input logic               br_taken,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic               retire_valid,
  input logic               bubble,
  input logic               ex_valid,
  input logic [INSTR_W-1:0] ex_word
);
  logic take_now;
  assign take_now = ex_valid && (ex_word[INSTR_W-1:OP_LSB] == OP_BRANCH) && br_taken && !stall;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0) && !retire_valid && !bubble);

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !take_now) |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

  // R5
  squash_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (take_now && !ex_word[DLY_BIT]) |=>
      (fetch_addr == $past(ex_word[ADDR_W-1:0])) ##1 !retire_valid ##1 !retire_valid);

  // R6
  delayed_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (take_now && ex_word[DLY_BIT]) |=>
      retire_valid && (fetch_addr == $past(ex_word[ADDR_W-1:0])));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(fetch_addr) && !retire_valid && bubble);

  // R10
  bubble_excl_chk: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> !bubble);
endmodule

bind branch_pipe_ctrl bpc_checker u_bpc_checker (
  .clk(clk), .rst(rst), .stall(stall), .br_taken(br_taken),
  .fetch_addr(fetch_addr), .retire_valid(retire_valid), .bubble(bubble),
  .ex_valid(ex_valid), .ex_word(ex_word)
);

// File: tb/test_branch_pipe_ctrl.sv
`timescale 1ns/1ps
module test_branch_pipe_ctrl;
  localparam int AW = 11;
  localparam int IW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic br_taken = 1'b0;
  logic [IW-1:0] fetch_word;
  logic [AW-1:0] fetch_addr, exec_pc, retire_pc;
  logic [IW-1:0] retire_word;
  logic retire_valid, bubble;

  always #2.5 clk = ~clk;

  logic [IW-1:0] imem [DEPTH];
  bit            take_tbl [DEPTH];
  assign fetch_word = imem[fetch_addr];

  branch_pipe_ctrl i_branch_pipe_ctrl (
    .clk(clk), .rst(rst), .stall(stall), .br_taken(br_taken),
    .fetch_word(fetch_word), .fetch_addr(fetch_addr), .exec_pc(exec_pc),
    .retire_valid(retire_valid), .retire_word(retire_word),
    .retire_pc(retire_pc), .bubble(bubble)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit is_br(input logic [IW-1:0] w);
    return w[15:12] == 4'hA;
  endfunction

  function automatic logic [IW-1:0] mk_br(input bit dly, input int tgt);
    return {4'hA, dly, 11'(tgt)};
  endfunction

  // reference model: queue of in-flight entries, oldest = execute
  typedef struct { bit v; int pc; logic [IW-1:0] w; } ent_t;
  ent_t q[$];
  int    mpc;
  bit    e_rv, e_bub;
  int    e_rpc;
  logic [IW-1:0] e_rw;
  string ev_tag = "R1";
  int    n_squash = 0, n_delay = 0, n_nt = 0, n_ign = 0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      q.push_back('{v:0, pc:0, w:'0});
      q.push_back('{v:0, pc:0, w:'0});
      mpc = 0; e_rv = 0; e_bub = 0; ev_tag = "R1";
    end else if (stall) begin
      e_rv = 0; e_bub = 1; ev_tag = "R7";
    end else begin
      ent_t ex;
      ex = q.pop_front();
      e_rv = ex.v; e_bub = !ex.v; e_rpc = ex.pc; e_rw = ex.w;
      q.push_back('{v:1, pc:mpc, w:imem[mpc]});
      ev_tag = "R2";
      if (ex.v && is_br(ex.w) && br_taken) begin
        if (!ex.w[11]) begin
          foreach (q[i]) q[i].v = 0;
          ev_tag = "R3 R5"; n_squash++;
        end else begin
          ev_tag = "R3 R6"; n_delay++;
        end
        mpc = int'(ex.w[10:0]);
      end else begin
        if (ex.v && is_br(ex.w)) begin ev_tag = "R4"; n_nt++; end
        else if (br_taken) begin ev_tag = "R8"; n_ign++; end
        mpc = (mpc + 1) % DEPTH;
      end
    end
  end

  task automatic compare();
    chk(fetch_addr == AW'(mpc), ev_tag, "fetch_addr", fetch_addr, mpc);
    chk(retire_valid == e_rv, ev_tag, "retire_valid", retire_valid, e_rv);
    if (e_rv) begin
      chk(retire_pc == AW'(e_rpc), ev_tag, "retire_pc", retire_pc, e_rpc);
      chk(retire_word == e_rw, ev_tag, "retire_word", retire_word, e_rw);
    end
    chk(bubble == e_bub, "R10", "bubble", bubble, e_bub);
    if (q.size() > 0 && q[0].v)
      chk(exec_pc == AW'(q[0].pc), "R9", "exec_pc", exec_pc, q[0].pc);
  endtask

  task automatic drive(input int stall_pct);
    stall = (($urandom % 100) < stall_pct);
    if (is_br(imem[exec_pc])) br_taken = take_tbl[exec_pc];
    else                      br_taken = 1'($urandom % 2); // R8 noise
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      imem[a] = {4'(a % 9), 12'(a)};
      take_tbl[a] = 0;
    end
    imem[20]  = mk_br(0, 100); take_tbl[20]  = 1;
    imem[104] = mk_br(1, 200); take_tbl[104] = 1;
    imem[205] = mk_br(0, 300); take_tbl[205] = 0;
    imem[210] = mk_br(1, 400); take_tbl[210] = 0;
    imem[215] = mk_br(0, 500); take_tbl[215] = 1;
    imem[500] = mk_br(0, 600); take_tbl[500] = 1;
    imem[600] = mk_br(1, 20);  take_tbl[600] = 1;

    // R1: reset state
    rst = 1;
    repeat (3) @(negedge clk);
    chk(fetch_addr == 0, "R1", "fetch_addr after reset", fetch_addr, 0);
    chk(retire_valid == 0, "R1", "retire_valid after reset", retire_valid, 0);
    chk(bubble == 0, "R1", "bubble after reset", bubble, 0);
    rst = 0; stall = 0; br_taken = 0;

    // R2: first retire three edges after the fetch of address 0
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      compare();
      if (k == 2) chk(retire_valid == 0, "R2", "no retire before fill", retire_valid, 0);
      if (k == 3) chk(retire_valid && retire_pc == 0, "R2", "first retire pc", retire_pc, 0);
      if (k == 5) chk(retire_pc == 2 && fetch_addr == 5, "R2", "steady pc", retire_pc, 2);
      br_taken = 0;
    end

    // main run: no stall, then random stalls
    for (int c = 0; c < 600; c++) begin
      @(negedge clk); compare(); drive(0);
    end
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk); compare(); drive(25);
    end

    // R1: reset in mid run
    rst = 1; stall = 0;
    @(negedge clk);
    chk(fetch_addr == 0 && retire_valid == 0, "R1", "mid-run reset", fetch_addr, 0);
    rst = 0;
    for (int c = 0; c < 800; c++) begin
      @(negedge clk); compare(); drive(15);
    end

    chk(n_squash > 0, "R5", "squashing branches seen", n_squash, 1);
    chk(n_delay > 0, "R6", "delayed branches seen", n_delay, 1);
    chk(n_nt > 0, "R4", "not-taken branches seen", n_nt, 1);
    chk(n_ign > 0, "R8", "ignored conditions seen", n_ign, 1);
    finish_run();
  end
endmodule